// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Flags

This block is a first-in first-out buffer of 1024 words of 18 bits. The write side and the read side each run on their own clock. Writes and reads use active-low enables. Five active-low status flags report the fill level:

- empty
- almost empty
- half full
- almost full
- full

Each flag is generated in the clock domain where it is useful. The block rejects a write into a full buffer and a read from an empty one.

Two 12-bit threshold registers set how close to empty and how close to full the two almost-flags switch. No separate configuration port exists. While the shared load strobe is low, write cycles store the low 12 bits of the write bus into the thresholds, and read cycles return the thresholds on the read bus.

Each side keeps its own select bit. The select alternates between the almost-empty threshold and the almost-full threshold, and it holds its position after the strobe is raised. A later programming session therefore continues with whichever threshold is next in turn. An output-enable input masks the read bus to zero.

Top module: `dcfifo_progflags`

## Requirements
- R1: With `ld_n` high, each `wclk` edge that samples `wr_en_n` low and finds the buffer not full stores `wdata`. Each `rclk` edge that samples `rd_en_n` low and finds the buffer not empty loads the oldest word into the read register. The word appears on `rdata` after that edge, and words leave in the order they were written.
- R2: `full_n` is low exactly when 1024 words are held. A write attempted while full is dropped, and the stored contents are unchanged.
- R3: `empty_n` is low exactly when no word is held. A read attempted while empty is dropped, and `rdata` keeps the last word that was read.
- R4: `half_n` is low exactly when more than 512 words are held.
- R5: `aempty_n` is low when the occupancy is less than or equal to the almost-empty threshold. This flag is produced in the `rclk` domain.
- R6: `afull_n` is low when the free space (1024 minus the occupancy) is less than or equal to the almost-full threshold. This flag is produced in the `wclk` domain.
- R7: While `ld_n` is low, a `wclk` edge with `wr_en_n` low stores `wdata[11:0]` into a threshold instead of into the buffer. The first such edge writes the almost-empty threshold, the second writes the almost-full threshold, and the third wraps back to almost-empty.
- R8: The write-side select keeps its position while `ld_n` is high. A new programming session continues the alternating order from where the previous session stopped.
- R9: While `ld_n` is low, an `rclk` edge with `rd_en_n` low loads one threshold into the read register, zero-extended to 18 bits. The threshold is chosen by a read-side select that alternates almost-empty, then almost-full, starting from almost-empty after reset. The buffer contents and the read pointer are not disturbed.
- R10: `rst_n` low asynchronously empties the buffer and sets both thresholds to 127. It also returns both selects to almost-empty and clears the read register. No write or read is accepted while `rst_n` is low.
- R11: `rdata` reads all zeros while `oe_n` is high, and shows the read register while `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; each domain releases it through its own synchronizer |
| ld_n | input | 1 | Active-low load strobe; routes write and read cycles to the thresholds |
| wr_en_n | input | 1 | Active-low write enable, sampled on `wclk` |
| wdata | input | 18 | Write data; bits 11:0 carry threshold values |
| rd_en_n | input | 1 | Active-low read enable, sampled on `rclk` |
| oe_n | input | 1 | Active-low output mask for `rdata` |
| rdata | output | 18 | Registered read data or threshold readback |
| empty_n | output | 1 | Low when empty (`rclk` domain) |
| aempty_n | output | 1 | Low when at or below the almost-empty threshold (`rclk` domain) |
| half_n | output | 1 | Low when more than half full (`wclk` domain) |
| afull_n | output | 1 | Low when the free space is at or below the almost-full threshold (`wclk` domain) |
| full_n | output | 1 | Low when full (`wclk` domain) |

## Verification
Two situations are hard to reach from the ports. One is the exact flag boundaries at the far end of the buffer, which sit a thousand writes away. The other is a programming session that begins with the select left on the almost-full threshold. The stimulus fills the buffer in directed stages and checks every flag on both sides of each boundary, for example at 20 and 21 words, 512 and 513, 993 and 994, and at 1024. It then tries more writes against the full buffer. The threshold sequence uses three single-cycle sessions separated by `ld_n` high, so the second session starts mid-rotation and the third wraps. After the directed stages, a seeded random mix of concurrent writes and reads runs on clocks of unequal period.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned DATA_W      = 18;
  localparam int unsigned ADDR_W      = 10;
  localparam int unsigned OFF_W       = 12;
  localparam int unsigned OFF_DEFAULT = 127;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } off_sel_e;
endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage0;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage0 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage0 <= 1'b1;
      srst_n <= stage0;
    end
  end
endmodule

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wword,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wword;
  end

  assign rword = store[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl #(
  parameter int unsigned AW          = 10,
  parameter int unsigned OW          = 12,
  parameter int unsigned OFF_DEFAULT = 127
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          ld_n,
  input  logic          wr_en_n,
  input  logic [OW-1:0] wlow,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off,
  output logic          full_n,
  output logic          afull_n,
  output logic          half_n
);
  import dcfifo_pkg::*;

  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] HALF_CNT = {2'b01, {(AW-1){1'b0}}};
  localparam logic [OW-1:0] OFF_RST  = OW'(OFF_DEFAULT);

  off_sel_e      wsel, wsel_nx;
  logic [PW-1:0] wbin_nx, rbin_s, wocc, wfree;
  logic [OW-1:0] ae_nx, af_nx;
  logic          full, prog;

  always_comb begin
    for (int i = 0; i < int'(PW); i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign wocc  = wbin - rbin_s;
  assign wfree = FULL_CNT - wocc;
  assign full  = (wocc == FULL_CNT);
  assign we    = ld_n & ~wr_en_n & ~full;
  assign prog  = ~ld_n & ~wr_en_n;

  always_comb begin
    wbin_nx = wbin;
    wsel_nx = wsel;
    ae_nx   = ae_off;
    af_nx   = af_off;
    if (we) wbin_nx = wbin + 1'b1;
    if (prog) begin
      if (wsel == SEL_AE) ae_nx = wlow;
      else                af_nx = wlow;
      wsel_nx = (wsel == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      wsel   <= SEL_AE;
      ae_off <= OFF_RST;
      af_off <= OFF_RST;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      wsel   <= wsel_nx;
      ae_off <= ae_nx;
      af_off <= af_nx;
    end
  end

  assign full_n  = ~full;
  assign afull_n = ~(32'(wfree) <= 32'(af_off));
  assign half_n  = ~(wocc > HALF_CNT);

  // R2
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wocc <= FULL_CNT);
  // R2
  full_drop_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && ld_n && !wr_en_n) |=> (wbin == $past(wbin)));
  // R7
  prog_rotate_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!ld_n && !wr_en_n) |=> (wsel != $past(wsel)));
  // R8
  sel_keep_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (ld_n || wr_en_n) |=> $stable(wsel));
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 10,
  parameter int unsigned OW = 12
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ld_n,
  input  logic          rd_en_n,
  input  logic [AW:0]   wgray_s,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  input  logic [DW-1:0] mem_word,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rdata_q,
  output logic          empty_n,
  output logic          aempty_n
);
  import dcfifo_pkg::*;

  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  off_sel_e      rsel, rsel_nx;
  logic [PW-1:0] rbin_nx, wbin_s, rocc;
  logic [DW-1:0] rdata_nx;
  logic          empty, pop, peek;

  always_comb begin
    for (int i = 0; i < int'(PW); i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign rocc  = wbin_s - rbin;
  assign empty = (rocc == '0);
  assign pop   = ld_n & ~rd_en_n & ~empty;
  assign peek  = ~ld_n & ~rd_en_n;

  always_comb begin
    rbin_nx  = rbin;
    rsel_nx  = rsel;
    rdata_nx = rdata_q;
    if (pop) begin
      rbin_nx  = rbin + 1'b1;
      rdata_nx = mem_word;
    end
    if (peek) begin
      rdata_nx = (rsel == SEL_AE) ? DW'(ae_off) : DW'(af_off);
      rsel_nx  = (rsel == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rsel    <= SEL_AE;
      rdata_q <= '0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      rsel    <= rsel_nx;
      rdata_q <= rdata_nx;
    end
  end

  assign empty_n  = ~empty;
  assign aempty_n = ~(32'(rocc) <= 32'(ae_off));

  // R3
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rocc <= FULL_CNT);
  // R3
  empty_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && ld_n && !rd_en_n) |=> $stable(rdata_q));
  // R1
  pop_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!empty && ld_n && !rd_en_n) |=> (rbin == $past(rbin) + 1'b1));
  // R9
  peek_ptr_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ld_n |=> $stable(rbin));
endmodule

// File: rtl/dcfifo_progflags.sv
module dcfifo_progflags #(
  parameter int unsigned DW          = dcfifo_pkg::DATA_W,
  parameter int unsigned AW          = dcfifo_pkg::ADDR_W,
  parameter int unsigned OW          = dcfifo_pkg::OFF_W,
  parameter int unsigned OFF_DEFAULT = dcfifo_pkg::OFF_DEFAULT
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en_n,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          half_n,
  output logic          afull_n,
  output logic          full_n
);
  localparam int unsigned PW = AW + 1;

  logic          wrst_n, rrst_n, we;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [OW-1:0] ae_off, af_off;
  logic [DW-1:0] mem_word, rdata_q;

  dcfifo_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  dcfifo_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  dcfifo_gray_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcfifo_gray_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(wbin[AW-1:0]), .wword(wdata),
    .raddr(rbin[AW-1:0]), .rword(mem_word)
  );

  dcfifo_wr_ctl #(.AW(AW), .OW(OW), .OFF_DEFAULT(OFF_DEFAULT)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .ld_n(ld_n), .wr_en_n(wr_en_n),
    .wlow(wdata[OW-1:0]), .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray),
    .we(we), .ae_off(ae_off), .af_off(af_off),
    .full_n(full_n), .afull_n(afull_n), .half_n(half_n)
  );

  dcfifo_rd_ctl #(.DW(DW), .AW(AW), .OW(OW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ld_n(ld_n), .rd_en_n(rd_en_n),
    .wgray_s(wgray_s), .ae_off(ae_off), .af_off(af_off),
    .mem_word(mem_word), .rbin(rbin), .rgray(rgray), .rdata_q(rdata_q),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assign rdata = oe_n ? '0 : rdata_q;

  // R11
  oe_mask_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    oe_n |-> (rdata == '0));
endmodule

// File: tb/tb_dcfifo_progflags.sv
`timescale 1ns/1ps
module tb_dcfifo_progflags;
  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n, ld_n, wr_en_n, rd_en_n, oe_n;
  logic [17:0] wdata, rdata;
  logic empty_n, aempty_n, half_n, afull_n, full_n;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo_progflags dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wr_en_n(wr_en_n),
    .wdata(wdata), .rd_en_n(rd_en_n), .oe_n(oe_n), .rdata(rdata),
    .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
    .afull_n(afull_n), .full_n(full_n)
  );

  int nchk = 0, nbad = 0;
  logic [17:0] q[$];
  int ae_m, af_m;
  bit wsel_m, rsel_m;
  logic [17:0] last_rd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_low(input int occ, input string which);
    case (which)
      "empty": return occ == 0;
      "full":  return occ == 1024;
      "half":  return occ > 512;
      "ae":    return occ <= ae_m;
      default: return (1024 - occ) <= af_m;
    endcase
  endfunction

  task automatic settle();
    repeat (10) @(negedge rclk);
    repeat (10) @(negedge wclk);
  endtask

  task automatic check_flags(input string tag);
    int n = q.size();
    settle();
    chk(empty_n  == !exp_low(n, "empty"), {"R3 empty_n ", tag}, empty_n, !exp_low(n, "empty"));
    chk(full_n   == !exp_low(n, "full"),  {"R2 full_n ", tag},  full_n,  !exp_low(n, "full"));
    chk(half_n   == !exp_low(n, "half"),  {"R4 half_n ", tag},  half_n,  !exp_low(n, "half"));
    chk(aempty_n == !exp_low(n, "ae"),    {"R5 aempty_n ", tag}, aempty_n, !exp_low(n, "ae"));
    chk(afull_n  == !exp_low(n, "af"),    {"R6 afull_n ", tag}, afull_n, !exp_low(n, "af"));
  endtask

  task automatic wr_cycle(input bit en, input logic [17:0] d);
    @(negedge wclk);
    wr_en_n = !en;
    wdata = d;
    if (en && full_n) q.push_back(d);
  endtask

  task automatic rd_cycle(input bit en);
    @(negedge rclk);
    chk(rdata == last_rd, "R1/R3 read data", rdata, last_rd);
    rd_en_n = !en;
    if (en && empty_n) last_rd = q.pop_front();
  endtask

  task automatic prog_write(input logic [11:0] v);
    @(negedge wclk);
    ld_n = 1'b0; wr_en_n = 1'b0; wdata = {6'h2A, v};
    @(negedge wclk);
    wr_en_n = 1'b1; ld_n = 1'b1;
    if (!wsel_m) ae_m = v; else af_m = v;
    wsel_m = !wsel_m;
  endtask

  task automatic readback();
    int e;
    @(negedge rclk);
    ld_n = 1'b0; rd_en_n = 1'b0;
    @(negedge rclk);
    e = rsel_m ? af_m : ae_m;
    chk(rdata == 18'(e), "R9 threshold readback", rdata, e);
    rd_en_n = 1'b1; ld_n = 1'b1;
    rsel_m = !rsel_m;
    last_rd = 18'(e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ld_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge wclk);
      wr_en_n = 1'b0; wdata = 18'(i);
    end
    @(negedge wclk); wr_en_n = 1'b1;
    rd_en_n = 1'b0;
    repeat (3) @(negedge rclk);
    rd_en_n = 1'b1;
    rst_n = 1'b1;
    q.delete(); ae_m = 127; af_m = 127; wsel_m = 0; rsel_m = 0; last_rd = '0;
    settle();
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) wr_cycle(1'b1, 18'($urandom));
    wr_cycle(1'b0, '0);
  endtask

  bit finished = 0;
  initial begin
    #3_000_000;
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ld_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; oe_n = 1'b0; wdata = '0;
    do_reset();

    // R10 reset state
    chk(rdata == 0, "R10 rdata after reset", rdata, 0);
    check_flags("R10 after reset");
    readback(); readback();  // R10 defaults 127, R9 order

    // R7 / R8 alternation across separate sessions
    prog_write(12'd40);
    prog_write(12'd30);
    prog_write(12'd20);
    check_flags("R7 programming leaves buffer empty");
    readback(); readback();

    // Staged fill across boundaries (R2 R4 R5 R6)
    fill_to(10);   check_flags("10 words");
    fill_to(20);   check_flags("20 words");
    fill_to(21);   check_flags("21 words");
    fill_to(512);  check_flags("512 words");
    fill_to(513);  check_flags("513 words");
    fill_to(993);  check_flags("993 words");
    fill_to(994);  check_flags("994 words");
    fill_to(1024); check_flags("1024 words");
    for (int i = 0; i < 20; i++) wr_cycle(1'b1, 18'h3FFFF);  // R2 dropped
    wr_cycle(1'b0, '0);
    chk(q.size() == 1024, "R2 model count", q.size(), 1024);
    check_flags("R2 after overfill");

    // Drain plus reads on empty (R1 R3)
    for (int i = 0; i < 1040; i++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    check_flags("R3 after drain");
    for (int i = 0; i < 8; i++) rd_cycle(1'b1);
    rd_cycle(1'b0);

    // Random concurrent traffic (R1)
    fork
      begin
        for (int i = 0; i < 3000; i++) wr_cycle(($urandom % 10) < 6, 18'($urandom));
        wr_cycle(1'b0, '0);
      end
      begin
        for (int i = 0; i < 2200; i++) rd_cycle(($urandom % 10) < 5);
        rd_cycle(1'b0);
      end
    join
    check_flags("R1 after random mix");
    while (q.size() > 0) rd_cycle(1'b1);
    rd_cycle(1'b0);
    check_flags("R1 drained");

    // R11 output mask
    wr_cycle(1'b1, 18'h2A5A5); wr_cycle(1'b0, '0);
    settle();
    rd_cycle(1'b1); rd_cycle(1'b0);
    @(negedge rclk); oe_n = 1'b1;
    @(negedge rclk);
    chk(rdata == 0, "R11 masked", rdata, 0);
    oe_n = 1'b0;
    @(negedge rclk);
    chk(rdata == last_rd, "R11 unmasked", rdata, last_rd);

    // R10 reset with content and programmed thresholds
    fill_to(50);
    settle();
    do_reset();
    chk(rdata == 0, "R10 rdata cleared", rdata, 0);
    check_flags("R10 reset with content");
    readback(); readback();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule